// File: doc/BRIEF.md
# Late-Resolving Branch Redirect and Shadow Squash Controller

This block drives the program counter of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) in which branches are resolved in the execute stage. Each cycle it picks the next fetch address. That address is the sequential successor unless the execute/memory pipeline register holds a taken-branch flag. When the flag is set, the stored branch target is loaded instead. The flag and the target are written by the execute stage when a live branch evaluates its condition as true.

A taken branch is discovered late, so three younger instructions have already entered the pipeline when the redirect happens. The controller keeps a valid bit for each pipeline register. In the cycle where the taken flag is visible, it clears the valid bits of the three shadow instructions. Their memory write and register write strobes are gated by those valid bits, so the shadow instructions have no architectural effect. A shadow instruction can still flow through decode and execute, but it can never raise the taken flag. A not-taken branch costs no cycles and squashes nothing.

The execute-stage decision, target and operation tags come from the surrounding datapath. In the bench they are driven as stimulus.

Top module: `brsq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the PC equals RESET_PC (default 0), all four stage valid bits (IF/ID, ID/EX, EX/MEM, MEM/WB) are 0, the taken flag is 0, and both write strobes are 0.
- R2: In every cycle where the taken flag is 0, the PC register advances by STEP (default 4) at the clock edge.
- R3: At a clock edge where the ID/EX instruction is valid, `ex_branch` and `ex_cond` are 1, and the taken flag is 0, the taken flag becomes 1 and `exmem_target` captures `ex_target`. In all other cases the flag becomes 0.
- R4: A taken branch fetched in cycle i sets the flag at the end of cycle i+2. The PC holds its target in cycle i+4, so the fetch-to-target distance is exactly four cycles.
- R5: The taken flag is never 1 in two consecutive cycles.
- R6: At an edge where the taken flag is 1, the IF/ID, ID/EX and EX/MEM valid bits are loaded with 0. The MEM/WB valid bit takes the previous EX/MEM valid bit.
- R7: A branch that sits in a taken branch's shadow never sets the taken flag, even with `ex_cond` = 1.
- R8: `mem_we` is 1 exactly when EX/MEM is valid and its store tag (latched from `ex_store`) is 1.
- R9: `reg_we` is 1 exactly when MEM/WB is valid and its register-write tag (latched from `ex_regwr` through EX/MEM) is 1.
- R10: A branch with `ex_cond` = 0 leaves the PC sequence unchanged and clears no valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_branch | input | 1 | Instruction in execute is a conditional branch |
| ex_cond | input | 1 | Branch condition evaluated true in execute |
| ex_target | input | ADDR_W | Branch target computed in execute |
| ex_store | input | 1 | Instruction in execute writes data memory |
| ex_regwr | input | 1 | Instruction in execute writes the register file |
| pc | output | ADDR_W | Current fetch address |
| squash | output | 1 | High in the cycle the three shadow instructions are killed |
| ifid_valid | output | 1 | IF/ID holds a live instruction |
| idex_valid | output | 1 | ID/EX holds a live instruction |
| exmem_valid | output | 1 | EX/MEM holds a live instruction |
| memwb_valid | output | 1 | MEM/WB holds a live instruction |
| exmem_taken | output | 1 | Taken-branch flag in EX/MEM |
| exmem_target | output | ADDR_W | Branch target latched in EX/MEM |
| mem_we | output | 1 | Gated data-memory write enable |
| reg_we | output | 1 | Gated register-file write enable |

## Verification
The hardest case to reach is a branch that sits in a shadow slot and whose condition is true. Only such a branch shows whether the shadow can raise the taken flag again. The bench's synthetic program places branches in adjacent words, so the second one of each pair is often in the first shadow slot. It also drives the execute tags for every instruction, squashed or not, so that a killed branch still presents a true condition. The run visits several hundred fetch addresses and includes a reset in the middle. A bench-side pipeline model gives the expected PC and strobes. A four-deep PC history confirms the fetch-to-target distance at every redirect.

// File: rtl/brsq_pkg.sv
package brsq_pkg;
   // Number of pipeline registers tracked (IF/ID, ID/EX, EX/MEM, MEM/WB)
   localparam int NUM_PREGS = 4;
   // Instructions fetched behind a branch resolved in EX
   localparam int SHADOW_LEN = 3;

   typedef enum logic [1:0] {
      PR_IFID  = 2'd0,
      PR_IDEX  = 2'd1,
      PR_EXMEM = 2'd2,
      PR_MEMWB = 2'd3
   } preg_e;

   typedef struct packed {
      logic store;
      logic regwr;
   } op_tag_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/brsq_pc_gen.sv
module brsq_pc_gen
   import brsq_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          STEP         = 4,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          ALIGN_TARGET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              redirect,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);
   localparam int                ALN      = $clog2(STEP);
   localparam logic [ADDR_W-1:0] STEP_V   = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] RST_V    = ADDR_W'(RESET_PC);

   logic [ADDR_W-1:0] tgt_eff;
   logic [ADDR_W-1:0] pc_nxt;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_w
         $error("brsq_pc_gen: ADDR_W out of range");
      end
      if (!is_pow2(STEP) || STEP < 2) begin : g_bad_step
         $error("brsq_pc_gen: STEP must be a power of two >= 2");
      end
      if ((RESET_PC % STEP) != 0) begin : g_bad_rst
         $error("brsq_pc_gen: RESET_PC not aligned to STEP");
      end

      if (ALIGN_TARGET) begin : g_align
         always_comb tgt_eff = {target[ADDR_W-1:ALN], {ALN{1'b0}}};
      end else begin : g_raw
         always_comb tgt_eff = target;
      end
   endgenerate

   always_comb begin
      pc_nxt = pc + STEP_V;
      if (redirect) pc_nxt = tgt_eff;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RST_V;
      else        pc <= pc_nxt;
   end

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> (pc == $past(pc) + STEP_V));

   // R4
   redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (pc == $past(tgt_eff)));
endmodule

// File: rtl/brsq_valid_pipe.sv
module brsq_valid_pipe
   import brsq_pkg::*;
#(
   parameter int NSTG  = NUM_PREGS,
   parameter int NKILL = SHADOW_LEN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   output logic [NSTG-1:0] valid
);
   generate
      if (NKILL < 1 || NKILL >= NSTG) begin : g_bad_kill
         $error("brsq_valid_pipe: NKILL must be in 1..NSTG-1");
      end

      for (genvar s = 0; s < NSTG; s++) begin : g_stage
         logic v_in;
         if (s == 0) begin : g_head
            // A fresh fetch is always live unless it is in the shadow
            always_comb v_in = ~kill;
         end else if (s < NKILL) begin : g_shadow
            always_comb v_in = valid[s-1] & ~kill;
         end else begin : g_safe
            always_comb v_in = valid[s-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) valid[s] <= 1'b0;
            else        valid[s] <= v_in;
         end
      end
   endgenerate

   // R6
   shadow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (valid[NKILL-1:0] == '0));

   // R6
   tail_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (valid[NKILL] == $past(valid[NKILL-1])));
endmodule

// File: rtl/brsq_exmem_reg.sv
module brsq_exmem_reg
   import brsq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_valid,
   input  logic              ex_branch,
   input  logic              ex_cond,
   input  logic [ADDR_W-1:0] ex_target,
   input  op_tag_t           ex_tag,
   output logic              taken,
   output logic [ADDR_W-1:0] target,
   output op_tag_t           tag
);
   logic resolve_taken;

   // The taken flag itself marks the current EX occupant as a shadow
   always_comb resolve_taken = ex_valid & ex_branch & ex_cond & ~taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken  <= 1'b0;
         target <= '0;
         tag    <= '0;
      end else begin
         taken  <= resolve_taken;
         target <= ex_target;
         tag    <= ex_tag;
      end
   end

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && ex_branch && ex_cond && !taken) |=>
         (taken && target == $past(ex_target)));

   // R5
   flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !taken);

   // R7
   no_live_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |=> !taken);
endmodule

// File: rtl/brsq_ctrl.sv
module brsq_ctrl
   import brsq_pkg::*;
#(
   parameter int          ADDR_W       = 32,
   parameter int          STEP         = 4,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          ALIGN_TARGET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_branch,
   input  logic              ex_cond,
   input  logic [ADDR_W-1:0] ex_target,
   input  logic              ex_store,
   input  logic              ex_regwr,
   output logic [ADDR_W-1:0] pc,
   output logic              squash,
   output logic              ifid_valid,
   output logic              idex_valid,
   output logic              exmem_valid,
   output logic              memwb_valid,
   output logic              exmem_taken,
   output logic [ADDR_W-1:0] exmem_target,
   output logic              mem_we,
   output logic              reg_we
);
   logic [NUM_PREGS-1:0] vbits;
   op_tag_t              ex_tag;
   op_tag_t              em_tag;
   logic                 mw_regwr;

   always_comb begin
      ex_tag.store = ex_store;
      ex_tag.regwr = ex_regwr;
   end

   brsq_pc_gen #(
      .ADDR_W      (ADDR_W),
      .STEP        (STEP),
      .RESET_PC    (RESET_PC),
      .ALIGN_TARGET(ALIGN_TARGET)
   ) i_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .redirect(exmem_taken),
      .target  (exmem_target),
      .pc      (pc)
   );

   brsq_valid_pipe #(
      .NSTG (NUM_PREGS),
      .NKILL(SHADOW_LEN)
   ) i_vld (
      .clk  (clk),
      .rst_n(rst_n),
      .kill (exmem_taken),
      .valid(vbits)
   );

   brsq_exmem_reg #(
      .ADDR_W(ADDR_W)
   ) i_exmem (
      .clk      (clk),
      .rst_n    (rst_n),
      .ex_valid (vbits[PR_IDEX]),
      .ex_branch(ex_branch),
      .ex_cond  (ex_cond),
      .ex_target(ex_target),
      .ex_tag   (ex_tag),
      .taken    (exmem_taken),
      .target   (exmem_target),
      .tag      (em_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mw_regwr <= 1'b0;
      else        mw_regwr <= em_tag.regwr;
   end

   always_comb begin
      squash      = exmem_taken;
      ifid_valid  = vbits[PR_IFID];
      idex_valid  = vbits[PR_IDEX];
      exmem_valid = vbits[PR_EXMEM];
      memwb_valid = vbits[PR_MEMWB];
      mem_we      = vbits[PR_EXMEM] & em_tag.store;
      reg_we      = vbits[PR_MEMWB] & mw_regwr;
   end

   // R8
   shadow_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exmem_taken |=> !mem_we);

   // R9
   shadow_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exmem_taken |-> ##2 !reg_we);

   // R10
   no_taken_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exmem_taken && ifid_valid) |=> idex_valid);
endmodule

// File: tb/test_brsq_ctrl.sv
module test_brsq_ctrl;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ex_branch = 1'b0, ex_cond = 1'b0, ex_store = 1'b0, ex_regwr = 1'b0;
   logic [AW-1:0] ex_target = '0;
   logic [AW-1:0] pc, exmem_target;
   logic          squash, ifid_valid, idex_valid, exmem_valid, memwb_valid;
   logic          exmem_taken, mem_we, reg_we;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   brsq_ctrl i_brsq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ex_branch(ex_branch), .ex_cond(ex_cond), .ex_target(ex_target),
      .ex_store(ex_store), .ex_regwr(ex_regwr),
      .pc(pc), .squash(squash),
      .ifid_valid(ifid_valid), .idex_valid(idex_valid),
      .exmem_valid(exmem_valid), .memwb_valid(memwb_valid),
      .exmem_taken(exmem_taken), .exmem_target(exmem_target),
      .mem_we(mem_we), .reg_we(reg_we)
   );

   // Synthetic program, computed from the word index
   function automatic bit p_br(input logic [AW-1:0] a);
      int w = int'(a >> 2);
      return (w % 8 == 1) || (w % 8 == 2) || (w % 8 == 5);
   endfunction
   function automatic bit p_cond(input logic [AW-1:0] a);
      int w = int'(a >> 2);
      return ((w + (w >> 3)) % 3) != 0;
   endfunction
   function automatic logic [AW-1:0] p_tgt(input logic [AW-1:0] a);
      int w = int'(a >> 2);
      return AW'(((w * 13 + 5) % 64) * 4);
   endfunction
   function automatic bit p_st(input logic [AW-1:0] a);
      return !p_br(a) && ((int'(a >> 2) % 3) == 0);
   endfunction
   function automatic bit p_rw(input logic [AW-1:0] a);
      return !p_br(a) && !p_st(a);
   endfunction

   // Bench pipeline model
   logic [AW-1:0] m_pc, m_aifid, m_aidex, m_tgt;
   bit m_vifid, m_videx, m_vem, m_vmw, m_tk, m_st, m_rw, m_mwrw;
   logic [AW-1:0] hist [0:4];
   int since_rst;

   task automatic model_reset();
      m_pc = '0; m_aifid = '0; m_aidex = '0; m_tgt = '0;
      m_vifid = 0; m_videx = 0; m_vem = 0; m_vmw = 0;
      m_tk = 0; m_st = 0; m_rw = 0; m_mwrw = 0;
      since_rst = 0;
      for (int k = 0; k < 5; k++) hist[k] = '0;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      bit killed;
      chk(pc == m_pc, "R2", "pc", pc, m_pc);
      chk(ifid_valid == m_vifid, "R6", "ifid_valid", AW'(ifid_valid), AW'(m_vifid));
      chk(idex_valid == m_videx, "R6", "idex_valid", AW'(idex_valid), AW'(m_videx));
      chk(exmem_valid == m_vem, "R10", "exmem_valid", AW'(exmem_valid), AW'(m_vem));
      chk(memwb_valid == m_vmw, "R6", "memwb_valid", AW'(memwb_valid), AW'(m_vmw));
      chk(exmem_taken == m_tk, "R3", "exmem_taken", AW'(exmem_taken), AW'(m_tk));
      chk(squash == m_tk, "R6", "squash", AW'(squash), AW'(m_tk));
      if (m_tk) chk(exmem_target == m_tgt, "R3", "exmem_target", exmem_target, m_tgt);
      chk(mem_we == (m_vem & m_st), "R8", "mem_we", AW'(mem_we), AW'(m_vem & m_st));
      chk(reg_we == (m_vmw & m_mwrw), "R9", "reg_we", AW'(reg_we), AW'(m_vmw & m_mwrw));
      // R7: taken flag with a valid EX/MEM never follows a flag cycle
      killed = (hist[1] + 4 != hist[0]) && since_rst >= 2;
      // R4: a redirect lands on the target of the branch fetched 4 cycles ago
      for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = pc;
      if (since_rst >= 5 && pc != hist[1] + 4) begin
         chk(p_br(hist[4]) && p_cond(hist[4]) && p_tgt(hist[4]) == pc,
             "R4", "redirect distance", pc, p_tgt(hist[4]));
      end
      if (killed && m_tk) chk(1'b0, "R7", "flag right after redirect", 1, 0);
   endtask

   task automatic model_step();
      bit kill, n_tk;
      kill = m_tk;
      n_tk = m_videx && p_br(m_aidex) && p_cond(m_aidex) && !kill;
      m_vmw = m_vem; m_mwrw = m_rw;
      m_vem = m_videx && !kill;
      m_st = p_st(m_aidex); m_rw = p_rw(m_aidex);
      m_videx = m_vifid && !kill;
      m_vifid = !kill;
      m_tk = n_tk; m_tgt = p_tgt(m_aidex);
      m_aidex = m_aifid; m_aifid = m_pc;
      m_pc = kill ? m_tgt_prev : m_pc + 4;
   endtask

   logic [AW-1:0] m_tgt_prev;

   task automatic run(input int ncyc);
      for (int c = 0; c < ncyc; c++) begin
         check_outputs();
         // EX stimulus for whatever instruction the model places in ID/EX,
         // squashed or not, so shadow branches present a true condition too
         ex_branch = p_br(m_aidex);
         ex_cond   = p_cond(m_aidex);
         ex_target = p_tgt(m_aidex);
         ex_store  = p_st(m_aidex);
         ex_regwr  = p_rw(m_aidex);
         m_tgt_prev = m_tgt;
         @(posedge clk);
         #1;
         model_step();
         since_rst++;
         @(negedge clk);
      end
   endtask

   task automatic reset_phase();
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1
      chk(pc == '0, "R1", "reset pc", pc, '0);
      chk({ifid_valid, idex_valid, exmem_valid, memwb_valid} == 4'b0,
          "R1", "reset valids", AW'({ifid_valid, idex_valid, exmem_valid, memwb_valid}), 0);
      chk(!exmem_taken && !mem_we && !reg_we, "R1", "reset flag/strobes",
          AW'({exmem_taken, mem_we, reg_we}), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      m_tgt_prev = '0;
      @(negedge clk);
      reset_phase();
      run(420);
      // mid-run reset after a stretch of branching
      reset_phase();
      run(300);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule